// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver

This block moves an 18-bit word between two ports, called A and B, with an independent path in each direction. Each path has one storage element. A latch enable makes that element transparent, so the opposite port follows the input. With the latch enable low, the element keeps its word and loads a new one only on a falling edge of the path's data clock. A separate active-low clock enable can block those edges. A per-direction active-low output enable decides whether the opposite port drives at all.

The design is fully synchronous to a fast system clock. Each data clock is sampled once per system clock and compared with its previous sample to find its falling edges. The tri-state outputs are modelled as a data word plus a valid flag. When a port does not drive, its flag is low and its data word is zero.

Top module: `ubt_xcvr`

## Requirements
- R1: While `rst_n` is low, both valid flags are low and both output words are zero. Both storage elements reset to zero, so after reset an enabled port with its latch enable low outputs 0.
- R2: While a direction's latch enable is high and its output enable is low, the output word equals the input word in the same cycle.
- R3: With the latch enable low and the data clock held static (high or low), the output word keeps its value whatever the input word does.
- R4: With the latch enable low and the clock enable low, a falling data clock edge loads the input word. A falling edge is a sample of 1 at one system clock edge followed by a sample of 0 at the next. The new word is visible from that second system clock edge on. A rising data clock edge loads nothing.
- R5: While the clock enable (active low) is high, falling data clock edges are ignored and the stored word is kept.
- R6: When the latch enable goes from high to low, the path keeps the input word that was present at the last system clock edge with the latch enable high.
- R7: When the output enable (active low) is high, that direction's valid flag is low and its output word is zero. When it is low, the valid flag is high.
- R8: The A-to-B path (inputs `a_in` and `ab_*`, outputs `b_out` and `b_out_vld`) and the B-to-A path (inputs `b_in` and `ba_*`, outputs `a_out` and `a_out_vld`) behave the same way, and neither affects the other.
- R9: All 18 bits pass and store independently. This holds for the alternating patterns 0x2AAAA and 0x15555 and for all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word arriving at port A |
| b_out | output | 18 | Word driven onto port B (zero when not driving) |
| b_out_vld | output | 1 | Port B is driving |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_dclk | input | 1 | A-to-B data clock, loads on its falling edge |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| b_in | input | 18 | Word arriving at port B |
| a_out | output | 18 | Word driven onto port A (zero when not driving) |
| a_out_vld | output | 1 | Port A is driving |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_dclk | input | 1 | B-to-A data clock, loads on its falling edge |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |

## Verification
Each direction is tried with the data clock falling, rising and held static, and with the clock enable both asserted and deasserted. The input word changes between steps, so a load that should or should not happen shows up as a different output word. Switching the latch enable while the input keeps changing separates combinational pass-through from a frozen stored word. Complementary bit patterns on the two ports at the same time expose any crossing between the directions or any bit stuck or swapped inside a path.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    localparam int unsigned UBT_WIDTH = 18;
    localparam int unsigned UBT_DIRS  = 2;

    // What the storage element does at the next system clock edge
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } ubt_mode_e;
endpackage

// File: rtl/ubt_fall_det.sv
module ubt_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    typedef struct packed {
        logic prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.prev = sig;
        fall       = det_q.prev & ~sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
    parameter int unsigned W = ubt_pkg::UBT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         dclk,
    input  logic         ce_n,
    input  logic         oe_n,
    output logic [W-1:0] dout,
    output logic         dout_vld
);
    import ubt_pkg::*;

    typedef struct packed {
        logic [W-1:0] word;
    } lane_t;

    lane_t     lane_d, lane_q;
    ubt_mode_e mode;
    logic      dclk_fall;
    logic [W-1:0] view;

    ubt_fall_det u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (dclk),
        .fall (dclk_fall)
    );

    always_comb begin
        if (le)                     mode = MODE_PASS;
        else if (dclk_fall && !ce_n) mode = MODE_CAPTURE;
        else                        mode = MODE_HOLD;

        lane_d = lane_q;
        case (mode)
            MODE_PASS, MODE_CAPTURE: lane_d.word = din;
            default:                 lane_d.word = lane_q.word;
        endcase

        view     = le ? din : lane_q.word;
        dout_vld = rst_n & ~oe_n;
        dout     = dout_vld ? view : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
    parameter int unsigned W = ubt_pkg::UBT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] b_out,
    output logic         b_out_vld,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_dclk,
    input  logic         ab_ce_n,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_out_vld,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_dclk,
    input  logic         ba_ce_n
);
    localparam int unsigned NDIR = ubt_pkg::UBT_DIRS;

    // index 0 carries A to B, index 1 carries B to A
    logic [W-1:0] lane_in  [NDIR];
    logic [W-1:0] lane_out [NDIR];
    logic         lane_vld [NDIR];
    logic         lane_le  [NDIR];
    logic         lane_clk [NDIR];
    logic         lane_ce  [NDIR];
    logic         lane_oe  [NDIR];

    assign lane_in[0]  = a_in;
    assign lane_le[0]  = ab_le;
    assign lane_clk[0] = ab_dclk;
    assign lane_ce[0]  = ab_ce_n;
    assign lane_oe[0]  = ab_oe_n;
    assign lane_in[1]  = b_in;
    assign lane_le[1]  = ba_le;
    assign lane_clk[1] = ba_dclk;
    assign lane_ce[1]  = ba_ce_n;
    assign lane_oe[1]  = ba_oe_n;

    for (genvar g = 0; g < NDIR; g++) begin : g_lane
        ubt_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (lane_in[g]),
            .le      (lane_le[g]),
            .dclk    (lane_clk[g]),
            .ce_n    (lane_ce[g]),
            .oe_n    (lane_oe[g]),
            .dout    (lane_out[g]),
            .dout_vld(lane_vld[g])
        );
    end

    assign b_out     = lane_out[0];
    assign b_out_vld = lane_vld[0];
    assign a_out     = lane_out[1];
    assign a_out_vld = lane_vld[1];
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_out,
    input logic         b_out_vld,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_dclk,
    input logic         ab_ce_n,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_out_vld,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_dclk,
    input logic         ba_ce_n
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!a_out_vld && !b_out_vld && a_out == '0 && b_out == '0));

    // R2
    ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && !ab_oe_n) |-> (b_out == a_in));

    // R8
    ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le && !ba_oe_n) |-> (a_out == b_in));

    // R5
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && $past(!ab_le) && $past(ab_ce_n) && !ab_oe_n && $past(!ab_oe_n))
        |-> $stable(b_out));

    // R4
    ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ba_le && !ba_ce_n && !ba_dclk && $past(ba_dclk))
        |=> (ba_le || ba_oe_n || a_out == $past(b_in)));

    // R7
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_oe_n |-> (!b_out_vld && b_out == '0)) and (ba_oe_n |-> (!a_out_vld && a_out == '0)));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb;
    localparam int  W       = 18;
    localparam time CLK_PER = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic [W-1:0] din [2];
    logic le [2], dck [2], ce_n [2], oe_n [2];
    logic [W-1:0] b_out, a_out;
    logic b_out_vld, a_out_vld;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PER/2) clk = ~clk;

    ubt_xcvr #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(din[0]), .b_out(b_out), .b_out_vld(b_out_vld),
        .ab_oe_n(oe_n[0]), .ab_le(le[0]), .ab_dclk(dck[0]), .ab_ce_n(ce_n[0]),
        .b_in(din[1]), .a_out(a_out), .a_out_vld(a_out_vld),
        .ba_oe_n(oe_n[1]), .ba_le(le[1]), .ba_dclk(dck[1]), .ba_ce_n(ce_n[1])
    );

    function automatic logic [W-1:0] out_of(int d);
        return (d == 0) ? b_out : a_out;
    endfunction

    function automatic logic vld_of(int d);
        return (d == 0) ? b_out_vld : a_out_vld;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one system clock edge, then move clear of it
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    // leave a direction in latched mode, enabled, with a known stored word
    task automatic load(int d, logic [W-1:0] v);
        le[d] = 0; ce_n[d] = 0; oe_n[d] = 0;
        dck[d] = 1; tick();
        din[d] = v; dck[d] = 0; tick();
    endtask

    task automatic t_reset();
        oe_n[0] = 0; oe_n[1] = 0;
        le[0] = 1; le[1] = 1;
        din[0] = 18'h3FFFF; din[1] = 18'h3FFFF;
        tick(); settle();
        check("R1 b_vld in reset", W'(b_out_vld), 0);
        check("R1 a_vld in reset", W'(a_out_vld), 0);
        check("R1 b_out in reset", b_out, 0);
        check("R1 a_out in reset", a_out, 0);
        le[0] = 0; le[1] = 0;
        rst_n = 1; tick(); settle();
        check("R1 b_out after reset", b_out, 0);
        check("R1 a_out after reset", a_out, 0);
    endtask

    task automatic t_transparent(int d);
        le[d] = 1; oe_n[d] = 0;
        foreach (din[d][i]) ;
        din[d] = 18'h2AAAA; settle();
        check("R2/R9 pass 2AAAA", out_of(d), 18'h2AAAA);
        din[d] = 18'h15555; settle();
        check("R2/R9 pass 15555", out_of(d), 18'h15555);
        tick();
        check("R2 pass after edge", out_of(d), 18'h15555);
    endtask

    task automatic t_hold_static(int d);
        load(d, 18'h0F0F0);
        check("R4 load visible", out_of(d), 18'h0F0F0);
        for (int i = 0; i < 3; i++) begin
            din[d] = W'(18'h11111 * (i + 1)); tick();
        end
        check("R3 hold clock low", out_of(d), 18'h0F0F0);
        dck[d] = 1; tick();
        din[d] = 18'h22222; tick(); tick();
        check("R3/R4 hold clock high after rise", out_of(d), 18'h0F0F0);
    endtask

    task automatic t_capture(int d);
        load(d, 18'h01234);
        dck[d] = 1; tick();
        din[d] = 18'h3FFFF; dck[d] = 0; settle();
        check("R4 before load edge", out_of(d), 18'h01234);
        tick();
        check("R4/R9 load all ones", out_of(d), 18'h3FFFF);
    endtask

    task automatic t_ce_block(int d);
        load(d, 18'h0ABCD);
        ce_n[d] = 1;
        dck[d] = 1; tick();
        din[d] = 18'h35555; dck[d] = 0; tick(); tick();
        check("R5 fall ignored", out_of(d), 18'h0ABCD);
        ce_n[d] = 0; tick(); tick();
        check("R5 no late load", out_of(d), 18'h0ABCD);
    endtask

    task automatic t_freeze(int d);
        oe_n[d] = 0; ce_n[d] = 0; dck[d] = 0;
        le[d] = 1; din[d] = 18'h1CAFE; tick();
        le[d] = 0; din[d] = 18'h00001; settle();
        check("R6 freeze on exit", out_of(d), 18'h1CAFE);
        tick(); tick();
        check("R6 frozen later", out_of(d), 18'h1CAFE);
    endtask

    task automatic t_oe(int d);
        load(d, 18'h2D2D2);
        oe_n[d] = 1; settle();
        check("R7 vld off", W'(vld_of(d)), 0);
        check("R7 out zero", out_of(d), 0);
        oe_n[d] = 0; settle();
        check("R7 vld on", W'(vld_of(d)), 1);
        check("R7 stored reappears", out_of(d), 18'h2D2D2);
    endtask

    task automatic t_independent();
        load(0, 18'h2AAAA);
        load(1, 18'h15555);
        dck[0] = 1; dck[1] = 0; tick();
        din[0] = 18'h3FFFF; din[1] = 18'h00000; dck[0] = 0; tick();
        check("R8 A-to-B loaded", b_out, 18'h3FFFF);
        check("R8 B-to-A untouched", a_out, 18'h15555);
        le[1] = 1; din[1] = 18'h0F00F; settle();
        check("R8 B-to-A pass", a_out, 18'h0F00F);
        check("R8 A-to-B kept", b_out, 18'h3FFFF);
        le[1] = 0;
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            din[d] = '0; le[d] = 0; dck[d] = 0; ce_n[d] = 0; oe_n[d] = 1;
        end
        t_reset();
        for (int d = 0; d < 2; d++) begin
            t_transparent(d);
            t_hold_static(d);
            t_capture(d);
            t_ce_block(d);
            t_freeze(d);
            t_oe(d);
        end
        t_independent();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule